// File: doc/BRIEF.md
# Bus Error Status Capture Register

This block records error events reported by a bus interface into a 64-bit status register and a companion address register, and drives an interrupt while any error is outstanding. Each event arrives on a single-cycle input with a kind code and its attributes: the byte mask, the faulting address and whether it was a block transfer. Three kinds are tracked: DMA read, DMA write and address-translation failure.

The first error seen while no primary flag is pending becomes the primary error. It sets its primary flag and freezes its byte mask, doubleword offset, block indication and full address. Any further error, while a primary flag remains pending, only sets the secondary flag of its kind, so the first failure stays intact for software to inspect. Software reads both registers through a small select/read/write port. It clears flags by writing ones to them. Writing zero to a flag leaves it untouched.

Top module: `err_capture_reg`

## Requirements
- R1: After synchronous reset the status register, the address register and `irq` are all zero.
- R2: An event with kind 0 (DMA read), 1 (DMA write) or 2 (translation), arriving while no primary flag is set, sets the primary flag of that kind: bit 62 for read, bit 61 for write, bit 56 for translation. At most one primary flag is ever set.
- R3: An event arriving while a primary flag is set sets only the secondary flag of its kind: bit 59 for read, bit 58 for write, bit 57 for translation. It leaves the primary flags, the captured fields and the address register unchanged.
- R4: A primary capture stores the byte mask in status bits 47:32, event address bits 5:3 in status bits 31:29 and the block indication in status bit 23. It also stores the full event address in the address register.
- R5: A status write (`reg_sel`=0) clears every flag bit written as 1 and keeps every flag written as 0. It never alters the captured fields (bits 47:32, 31:29, 23).
- R6: The address register (`reg_sel`=1) is read-only, and writes to it are ignored.
- R7: `irq` is 1 exactly when `irq_en` is 1 and at least one of the six flags is set.
- R8: When an event and a status write arrive in the same cycle, the clear is applied first and the event is then applied to the result. A clear of the pending primary therefore lets the event become a new primary capture, and the event's flag is always set afterwards.
- R9: An event with kind code 3 is ignored.
- R10: Status bits other than 62, 61, 59..56, 47:32, 31:29 and 23 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_kind | input | 2 | 0 read, 1 write, 2 translation, 3 none |
| evt_bmask | input | MASK_W | Byte mask of failing access |
| evt_addr | input | ADDR_W | Physical address of failing access |
| evt_block | input | 1 | Failing access was a block transfer |
| reg_sel | input | 1 | 0 status register, 1 address register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data (status: ones clear flags) |
| reg_rdata | output | 64 | Read data of the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Error interrupt |

## Verification
An event or write applied before a rising edge shows up in both registers right after that edge, so every result is due one cycle after its stimulus. The read port is combinational from the registers and the select, and `irq` follows the flags in the same cycle they change. The bench therefore drives inputs on a falling edge and removes them on the next falling edge. It then sets the select, waits a short delay and compares, so each sample falls half a cycle after the edge that produced it. Checks of `irq` are made in the same way, after `irq_en` has been changed and has had time to settle.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;

    typedef enum logic [1:0] {
        EK_RD   = 2'd0,
        EK_WR   = 2'd1,
        EK_XL   = 2'd2,
        EK_NONE = 2'd3
    } err_kind_e;

    localparam int BIT_PRIM_RD = 62;
    localparam int BIT_PRIM_WR = 61;
    localparam int BIT_SEC_RD  = 59;
    localparam int BIT_SEC_WR  = 58;
    localparam int BIT_SEC_XL  = 57;
    localparam int BIT_PRIM_XL = 56;
    localparam int BMASK_LSB   = 32;
    localparam int BMASK_W     = 16;
    localparam int OFF_LSB     = 29;
    localparam int OFF_W       = 3;
    localparam int BLK_BIT     = 23;
    localparam int REG_W       = 64;

    typedef struct packed {
        logic prim_rd;
        logic prim_wr;
        logic prim_xl;
        logic sec_rd;
        logic sec_wr;
        logic sec_xl;
    } err_flags_t;

    typedef struct packed {
        logic [BMASK_W-1:0] bmask;
        logic [OFF_W-1:0]   dw_off;
        logic               block;
    } err_attr_t;

    function automatic err_flags_t flags_from_word(input logic [REG_W-1:0] w);
        err_flags_t f;
        f.prim_rd = w[BIT_PRIM_RD];
        f.prim_wr = w[BIT_PRIM_WR];
        f.prim_xl = w[BIT_PRIM_XL];
        f.sec_rd  = w[BIT_SEC_RD];
        f.sec_wr  = w[BIT_SEC_WR];
        f.sec_xl  = w[BIT_SEC_XL];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input err_flags_t f,
                                                      input err_attr_t  a);
        logic [REG_W-1:0] s;
        s = '0;
        s[BIT_PRIM_RD] = f.prim_rd;
        s[BIT_PRIM_WR] = f.prim_wr;
        s[BIT_PRIM_XL] = f.prim_xl;
        s[BIT_SEC_RD]  = f.sec_rd;
        s[BIT_SEC_WR]  = f.sec_wr;
        s[BIT_SEC_XL]  = f.sec_xl;
        s[BMASK_LSB +: BMASK_W] = a.bmask;
        s[OFF_LSB +: OFF_W]     = a.dw_off;
        s[BLK_BIT]              = a.block;
        return s;
    endfunction

    function automatic logic any_primary(input err_flags_t f);
        return f.prim_rd | f.prim_wr | f.prim_xl;
    endfunction

endpackage

// File: rtl/err_cap_flags.sv
module err_cap_flags
    import err_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_fire,
    input  err_kind_e  evt_kind,
    input  err_flags_t clr,
    output err_flags_t flags_q,
    output logic       capture
);
    err_flags_t after_clr;
    err_flags_t flags_d;
    logic       prim_busy;

    always_comb begin
        after_clr = err_flags_t'(flags_q & ~clr);
        prim_busy = any_primary(after_clr);
        capture   = evt_fire && !prim_busy;
        flags_d   = after_clr;
        if (evt_fire) begin
            unique case (evt_kind)
                EK_RD: if (prim_busy) flags_d.sec_rd = 1'b1; else flags_d.prim_rd = 1'b1;
                EK_WR: if (prim_busy) flags_d.sec_wr = 1'b1; else flags_d.prim_wr = 1'b1;
                EK_XL: if (prim_busy) flags_d.sec_xl = 1'b1; else flags_d.prim_xl = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assert_one_primary_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags_q.prim_rd, flags_q.prim_wr, flags_q.prim_xl}));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (clr.sec_wr && !(evt_fire && evt_kind == EK_WR)) |=> !flags_q.sec_wr);

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_fire && evt_kind == EK_RD) |=> (flags_q.prim_rd || flags_q.sec_rd));

endmodule

// File: rtl/err_cap_attr.sv
module err_cap_attr
    import err_cap_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BMASK_W-1:0] evt_bmask,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              evt_block,
    output err_attr_t         attr_q,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int OFF_SRC_LSB = 3;

    err_attr_t attr_d;

    always_comb begin
        attr_d.bmask  = evt_bmask;
        attr_d.dw_off = evt_addr[OFF_SRC_LSB +: OFF_W];
        attr_d.block  = evt_block;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q <= '0;
            addr_q <= '0;
        end else if (capture) begin
            attr_q <= attr_d;
            addr_q <= evt_addr;
        end
    end

    assert_hold_fields_R3: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(attr_q) && $stable(addr_q)));

endmodule

// File: rtl/err_capture_reg.sv
module err_capture_reg
    import err_cap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [MASK_W-1:0] evt_bmask,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              evt_block,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              irq_en,
    output logic              irq
);
    localparam int PAD_W = REG_W - ADDR_W;

    err_kind_e   kind;
    logic        evt_fire;
    err_flags_t  clr;
    err_flags_t  flags_q;
    logic        capture;
    err_attr_t   attr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  addr_word;

    assign kind     = err_kind_e'(evt_kind);
    assign evt_fire = evt_valid && (kind != EK_NONE);
    assign clr      = (reg_wr && !reg_sel) ? flags_from_word(reg_wdata) : '0;

    err_cap_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt_fire (evt_fire),
        .evt_kind (kind),
        .clr      (clr),
        .flags_q  (flags_q),
        .capture  (capture)
    );

    err_cap_attr #(.ADDR_W(ADDR_W)) u_attr (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .evt_bmask (evt_bmask[BMASK_W-1:0]),
        .evt_addr  (evt_addr),
        .evt_block (evt_block),
        .attr_q    (attr_q),
        .addr_q    (addr_q)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_word = {{PAD_W{1'b0}}, addr_q};
        end else begin : g_nopad
            assign addr_word = addr_q[REG_W-1:0];
        end
    endgenerate

    assign reg_rdata = reg_sel ? addr_word : pack_status(flags_q, attr_q);
    assign irq       = irq_en && (|flags_q);

    assert_addr_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && !evt_valid) |=> $stable(addr_q));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_kind3_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'd3 && !reg_wr) |=> $stable(flags_q));

endmodule

// File: tb/err_capture_reg_bench.sv
module err_capture_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        evt_valid;
    logic [1:0]  evt_kind;
    logic [15:0] evt_bmask;
    logic [63:0] evt_addr;
    logic        evt_block;
    logic        reg_sel;
    logic        reg_wr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        irq_en;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    err_capture_reg u_err_capture_reg (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_bmask(evt_bmask), .evt_addr(evt_addr), .evt_block(evt_block),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq)
    );

    // act: 0 event, 1 status write (wdata = {lo32, 32'h0}), 2 address write, 3 idle
    // fields: act[148:147] kind[146:145] blk[144] bmask[143:128] lo32[127:96] exp_st[95:32] exp_addr[31:0]
    localparam int NV = 11;
    localparam logic [148:0] TBL [NV] = '{
        {2'd0, 2'd0, 1'b1, 16'h00F0, 32'h0000_1238, 64'h4000_00F0_E080_0000, 32'h0000_1238},
        {2'd0, 2'd1, 1'b0, 16'hFFFF, 32'h0000_0010, 64'h4400_00F0_E080_0000, 32'h0000_1238},
        {2'd0, 2'd2, 1'b0, 16'h1111, 32'h0000_0020, 64'h4600_00F0_E080_0000, 32'h0000_1238},
        {2'd0, 2'd3, 1'b1, 16'h2222, 32'h0000_0028, 64'h4600_00F0_E080_0000, 32'h0000_1238},
        {2'd2, 2'd0, 1'b0, 16'h0000, 32'hDEAD_BEEF, 64'h4600_00F0_E080_0000, 32'h0000_1238},
        {2'd1, 2'd0, 1'b0, 16'h0000, 32'h0400_0000, 64'h4200_00F0_E080_0000, 32'h0000_1238},
        {2'd1, 2'd0, 1'b0, 16'h0000, 32'h0000_0000, 64'h4200_00F0_E080_0000, 32'h0000_1238},
        {2'd1, 2'd0, 1'b0, 16'h0000, 32'h4200_0000, 64'h0000_00F0_E080_0000, 32'h0000_1238},
        {2'd0, 2'd2, 1'b0, 16'h0003, 32'h0000_0008, 64'h0100_0003_2000_0000, 32'h0000_0008},
        {2'd0, 2'd0, 1'b1, 16'h0404, 32'h0000_0038, 64'h0900_0003_2000_0000, 32'h0000_0008},
        {2'd1, 2'd0, 1'b0, 16'h0000, 32'h7F00_0000, 64'h0000_0003_2000_0000, 32'h0000_0008}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [63:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic idle_inputs();
        evt_valid = 1'b0; evt_kind = 2'd0; evt_bmask = '0; evt_addr = '0;
        evt_block = 1'b0; reg_wr = 1'b0; reg_wdata = '0; reg_sel = 1'b0;
    endtask

    // one cycle: drive at falling edge, release at next falling edge
    task automatic cycle_drive(input logic ev, input logic [1:0] k, input logic [15:0] bm,
                               input logic [63:0] ad, input logic blk,
                               input logic wr, input logic sel, input logic [63:0] wd);
        @(negedge clk);
        evt_valid = ev; evt_kind = k; evt_bmask = bm; evt_addr = ad; evt_block = blk;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [63:0] v;
        rst = 1'b1;
        irq_en = 1'b1;
        idle_inputs();
        fork
            begin
                do_reset();
                // R1 reset state
                read_reg(1'b0, v); check("R1 status after reset", v, 64'h0);
                read_reg(1'b1, v); check("R1 address after reset", v, 64'h0);
                check("R1 irq after reset", {63'h0, irq}, 64'h0);

                // table walk: R2 R3 R4 R5 R6 R9 R10
                for (int i = 0; i < NV; i++) begin
                    logic [148:0] e;
                    e = TBL[i];
                    case (e[148:147])
                        2'd0: cycle_drive(1'b1, e[146:145], e[143:128], {32'h0, e[127:96]},
                                          e[144], 1'b0, 1'b0, 64'h0);
                        2'd1: cycle_drive(1'b0, 2'd0, 16'h0, 64'h0, 1'b0, 1'b1, 1'b0,
                                          {e[127:96], 32'h0});
                        2'd2: cycle_drive(1'b0, 2'd0, 16'h0, 64'h0, 1'b0, 1'b1, 1'b1,
                                          {e[127:96], e[127:96]});
                        default: cycle_drive(1'b0, 2'd0, 16'h0, 64'h0, 1'b0, 1'b0, 1'b0, 64'h0);
                    endcase
                    read_reg(1'b0, v);
                    check($sformatf("R2/R3/R4/R5/R9/R10 status step %0d", i), v, e[95:32]);
                    read_reg(1'b1, v);
                    check($sformatf("R4/R6 address step %0d", i), v, {32'h0, e[31:0]});
                end

                // R7: no flags -> irq low even when enabled
                check("R7 irq low with no flags", {63'h0, irq}, 64'h0);
                cycle_drive(1'b1, 2'd1, 16'h8001, 64'hFFFF_0000_0000_0018, 1'b1, 1'b0, 1'b0, 64'h0);
                // R4 full 64-bit address and primary write bit 61
                read_reg(1'b1, v); check("R4 full address", v, 64'hFFFF_0000_0000_0018);
                read_reg(1'b0, v); check("R2 primary write", v, 64'h2000_8001_6080_0000);
                check("R7 irq high with flag and enable", {63'h0, irq}, 64'h1);
                irq_en = 1'b0; #1;
                check("R7 irq low when disabled", {63'h0, irq}, 64'h0);
                irq_en = 1'b1; #1;

                // R8: clear primary write and new read event same cycle -> new primary capture
                cycle_drive(1'b1, 2'd0, 16'h00AA, 64'h0000_0000_0000_0030, 1'b0,
                            1'b1, 1'b0, 64'h2000_0000_0000_0000);
                read_reg(1'b0, v); check("R8 clear plus event -> new primary", v, 64'h4000_00AA_C000_0000);
                read_reg(1'b1, v); check("R8 new address captured", v, 64'h30);

                // R8: clear secondary read while a read event arrives with primary pending
                cycle_drive(1'b1, 2'd0, 16'h0001, 64'h8, 1'b1, 1'b0, 1'b0, 64'h0);
                cycle_drive(1'b1, 2'd0, 16'h0002, 64'h10, 1'b1, 1'b1, 1'b0, 64'h0800_0000_0000_0000);
                read_reg(1'b0, v); check("R8 secondary read survives clear", v, 64'h4800_00AA_C000_0000);

                // R1: mid-run reset clears everything
                do_reset();
                read_reg(1'b0, v); check("R1 status after second reset", v, 64'h0);
                read_reg(1'b1, v); check("R1 address after second reset", v, 64'h0);
                check("R1 irq after second reset", {63'h0, irq}, 64'h0);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule